// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a single-port synchronous memory with a shared data bus. It takes one command per enabled clock edge and never needs an idle cycle between a read and a write. A read returns its word one enabled edge after the command is captured. A write takes its data from the bus two enabled edges after its command. Both data phases therefore fall in the same bus cycle, counted from the command, so commands can mix freely. Writes go through a one-entry pending slot before they reach the array. Any read that hits a newer write still in flight gets that write's bytes merged in.

A load command opens a four-word burst. Later advance cycles step only the two low address bits, either in linear order or in interleaved (XOR) order. Three synchronous chip selects qualify each load, and per-half byte selects gate each write. The bus has no valid/ready handshake. The clock enable is the only back-pressure: while it is high, every stage holds its state, in both directions. An asynchronous output enable can silence the drivers at any time.

Top module: `pipe_sram`

## Requirements
- R1: A read captured at enabled edge n (adv_ld_n low, we_n high, chip selects active) drives its word on dq_o with dq_oe high from enabled edge n+1 until enabled edge n+2.
- R2: While cke_n is high, clock edges change no state: dq_o, dq_oe and all pending commands hold, and other inputs are ignored.
- R3: Reads, writes and deselects may follow each other in any mix on consecutive enabled edges, and each one takes effect with no inserted cycle.
- R4: A write is a load with we_n low. Its data on dq_i is sampled at enabled edge n+2. bw_n is sampled with each command (load or advance) and is active low: bw_n[0] enables bits 8:0 and bw_n[1] enables bits 17:9. Unselected bits keep their old value.
- R5: A load is accepted only when sel1_n is low, sel2 is high and sel3_n is low. Otherwise it is a deselect: nothing is written and dq_oe is low in its data window.
- R6: In the data window of a write (from enabled edge n+1 to n+2), dq_oe is low.
- R7: With adv_ld_n high after an accepted load, the burst continues. In linear mode (burst_il low at the load), the low two address bits are (start + count) mod 4. The upper bits stay unchanged, and the burst wraps after 4 words.
- R8: In interleaved mode (burst_il high at the load), the low two address bits are start XOR count. burst_il is ignored on advance cycles.
- R9: An advance keeps the read or write type of its load and ignores we_n, the chip selects and addr. An advance after a deselect is again a deselect.
- R10: A read returns the newest data for its address per byte, including writes not yet in the array and a write whose data is sampled at the same edge the read word is loaded.
- R11: oe_n high forces dq_oe low combinationally, whatever the pipeline state.
- R12: After reset, dq_oe and dq_o are zero and no command is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of pipeline state |
| cke_n | input | 1 | Clock enable, active low; high holds all state |
| sel1_n | input | 1 | Chip select, active low |
| sel2 | input | 1 | Chip select, active high |
| sel3_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write command on a load, active low |
| bw_n | input | NBYTE (2) | Per-half write enables, active low |
| addr | input | ADDR_W (6) | Word address, used on loads |
| adv_ld_n | input | 1 | Low: load a new command; high: advance the burst |
| burst_il | input | 1 | Burst order on a load: 0 linear, 1 interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_i | input | 18 | Bus value seen by the memory (write data) |
| dq_o | output | 18 | Registered read data |
| dq_oe | output | 1 | Bus driver enable |

## Verification
A command issued in the cycle ending at enabled edge n has its result checked in the window after enabled edge n+1. For a read, that is the word with dq_oe high. For a write or deselect, it is dq_oe low. Write data is put on dq_i only in the cycle that ends at enabled edge n+2. The bench counts enabled edges itself and tags every expected item with its due count, so stalls move the due point exactly as they move the pipeline. Outputs are sampled one time unit after each rising edge. The stall check compares the outputs across a disabled edge. The output-enable check samples one unit after oe_n changes, within a single cycle.

// File: rtl/pipe_sram_pkg.sv
package pipe_sram_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } sram_op_e;

  typedef enum logic {
    ORDER_LINEAR     = 1'b0,
    ORDER_INTERLEAVE = 1'b1
  } burst_order_e;
endpackage

// File: rtl/pipe_sram_array.sv
module pipe_sram_array #(
  parameter int ADDR_W = 6,
  parameter int BYTE_W = 9,
  parameter int NBYTE  = 2
) (
  input  logic                      clk,
  input  logic                      we,
  input  logic [ADDR_W-1:0]         waddr,
  input  logic [NBYTE-1:0]          wbe,
  input  logic [BYTE_W*NBYTE-1:0]   wdata,
  input  logic [ADDR_W-1:0]         raddr,
  output logic [BYTE_W*NBYTE-1:0]   rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  // one storage lane per byte, so a byte enable needs no read-modify-write
  for (genvar g = 0; g < NBYTE; g++) begin : g_lane
    logic [BYTE_W-1:0] lane [DEPTH];

    always_ff @(posedge clk) begin
      if (we && wbe[g]) lane[waddr] <= wdata[g*BYTE_W +: BYTE_W];
    end

    assign rdata[g*BYTE_W +: BYTE_W] = lane[raddr];
  end
endmodule

// File: rtl/pipe_sram_cmd.sv
module pipe_sram_cmd
  import pipe_sram_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int BURST_W = 2,
  parameter int NBYTE   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              load,
  input  logic              sel_ok,
  input  logic              wr_req,
  input  logic              order_req,
  input  logic [NBYTE-1:0]  be_req,
  input  logic [ADDR_W-1:0] addr,
  output sram_op_e          a_op,
  output logic [ADDR_W-1:0] a_addr,
  output logic [NBYTE-1:0]  a_be
);
  sram_op_e            op_q;
  burst_order_e        ord_q;
  logic [ADDR_W-1:0]   base_q;
  logic [BURST_W-1:0]  cnt_q;
  logic [NBYTE-1:0]    be_q;
  logic [BURST_W-1:0]  low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_NONE;
      ord_q  <= ORDER_LINEAR;
      base_q <= '0;
      cnt_q  <= '0;
      be_q   <= '0;
    end else if (en) begin
      be_q <= be_req;
      if (load) begin
        cnt_q <= '0;
        if (sel_ok) begin
          op_q   <= wr_req ? OP_WRITE : OP_READ;
          base_q <= addr;
          ord_q  <= burst_order_e'(order_req);
        end else begin
          op_q <= OP_NONE;
        end
      end else if (op_q != OP_NONE) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // burst position: modulo add or XOR on the low bits only
  always_comb begin
    if (ord_q == ORDER_INTERLEAVE) low = base_q[BURST_W-1:0] ^ cnt_q;
    else                           low = base_q[BURST_W-1:0] + cnt_q;
  end

  assign a_op   = op_q;
  assign a_addr = {base_q[ADDR_W-1:BURST_W], low};
  assign a_be   = be_q;

  AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && load && !sel_ok) |=> (a_op == OP_NONE)); // R5

  AST_BURST_IN_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !load && a_op != OP_NONE) |=>
      (a_op == $past(a_op) && $stable(a_addr[ADDR_W-1:BURST_W]) && a_addr != $past(a_addr))); // R7

  AST_ADVANCE_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !load && a_op == OP_NONE) |=> (a_op == OP_NONE)); // R9
endmodule

// File: rtl/pipe_sram_wbuf.sv
module pipe_sram_wbuf
  import pipe_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int BYTE_W = 9,
  parameter int NBYTE  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  sram_op_e                a_op,
  input  logic [ADDR_W-1:0]       a_addr,
  input  logic [NBYTE-1:0]        a_be,
  input  logic [BYTE_W*NBYTE-1:0] wdata,
  output logic [BYTE_W*NBYTE-1:0] rd_word
);
  localparam int DATA_W = BYTE_W * NBYTE;

  // second command stage: write waiting for its data
  logic              b_wr_q;
  logic [ADDR_W-1:0] b_addr_q;
  logic [NBYTE-1:0]  b_be_q;
  // pending slot: write whose data is known but not yet in the array
  logic              pend_vld_q;
  logic [ADDR_W-1:0] pend_addr_q;
  logic [NBYTE-1:0]  pend_be_q;
  logic [DATA_W-1:0] pend_data_q;

  logic              commit;
  logic [DATA_W-1:0] arr_word;
  logic              hit_new, hit_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_wr_q      <= 1'b0;
      b_addr_q    <= '0;
      b_be_q      <= '0;
      pend_vld_q  <= 1'b0;
      pend_addr_q <= '0;
      pend_be_q   <= '0;
      pend_data_q <= '0;
    end else if (en) begin
      b_wr_q   <= (a_op == OP_WRITE);
      b_addr_q <= a_addr;
      b_be_q   <= a_be;
      if (b_wr_q) begin
        pend_vld_q  <= 1'b1;
        pend_addr_q <= b_addr_q;
        pend_be_q   <= b_be_q;
        pend_data_q <= wdata;
      end
    end
  end

  // the older pending write moves into the array when a newer one replaces it
  assign commit = en && b_wr_q && pend_vld_q;

  pipe_sram_array #(
    .ADDR_W (ADDR_W),
    .BYTE_W (BYTE_W),
    .NBYTE  (NBYTE)
  ) u_array (
    .clk   (clk),
    .we    (commit),
    .waddr (pend_addr_q),
    .wbe   (pend_be_q),
    .wdata (pend_data_q),
    .raddr (a_addr),
    .rdata (arr_word)
  );

  assign hit_new  = b_wr_q && (b_addr_q == a_addr);
  assign hit_pend = pend_vld_q && (pend_addr_q == a_addr);

  // newest source wins per byte: bus data, then pending slot, then array
  for (genvar g = 0; g < NBYTE; g++) begin : g_fwd
    assign rd_word[g*BYTE_W +: BYTE_W] =
      (hit_new  && b_be_q[g])    ? wdata[g*BYTE_W +: BYTE_W]       :
      (hit_pend && pend_be_q[g]) ? pend_data_q[g*BYTE_W +: BYTE_W] :
                                   arr_word[g*BYTE_W +: BYTE_W];
  end

  AST_PEND_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && b_wr_q) |=>
      (pend_vld_q && pend_addr_q == $past(b_addr_q) && pend_data_q == $past(wdata))); // R4

  AST_PEND_PERSIST: assert property (@(posedge clk) disable iff (!rst_n)
    pend_vld_q |=> pend_vld_q); // R10
endmodule

// File: rtl/pipe_sram.sv
module pipe_sram
  import pipe_sram_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int BYTE_W  = 9,
  parameter int NBYTE   = 2,
  parameter int BURST_W = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cke_n,
  input  logic                      sel1_n,
  input  logic                      sel2,
  input  logic                      sel3_n,
  input  logic                      we_n,
  input  logic [NBYTE-1:0]          bw_n,
  input  logic [ADDR_W-1:0]         addr,
  input  logic                      adv_ld_n,
  input  logic                      burst_il,
  input  logic                      oe_n,
  input  logic [BYTE_W*NBYTE-1:0]   dq_i,
  output logic [BYTE_W*NBYTE-1:0]   dq_o,
  output logic                      dq_oe
);
  localparam int DATA_W = BYTE_W * NBYTE;

  logic              en;
  logic              sel_ok;
  sram_op_e          a_op;
  logic [ADDR_W-1:0] a_addr;
  logic [NBYTE-1:0]  a_be;
  logic [DATA_W-1:0] rd_word;
  logic [DATA_W-1:0] dout_q;
  logic              drv_q;

  assign en     = !cke_n;
  assign sel_ok = !sel1_n && sel2 && !sel3_n;

  pipe_sram_cmd #(
    .ADDR_W  (ADDR_W),
    .BURST_W (BURST_W),
    .NBYTE   (NBYTE)
  ) u_cmd (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .load      (!adv_ld_n),
    .sel_ok    (sel_ok),
    .wr_req    (!we_n),
    .order_req (burst_il),
    .be_req    (~bw_n),
    .addr      (addr),
    .a_op      (a_op),
    .a_addr    (a_addr),
    .a_be      (a_be)
  );

  pipe_sram_wbuf #(
    .ADDR_W (ADDR_W),
    .BYTE_W (BYTE_W),
    .NBYTE  (NBYTE)
  ) u_wbuf (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .a_op    (a_op),
    .a_addr  (a_addr),
    .a_be    (a_be),
    .wdata   (dq_i),
    .rd_word (rd_word)
  );

  // output register: drives only for reads, keeps last word otherwise
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
      drv_q  <= 1'b0;
    end else if (en) begin
      drv_q <= (a_op == OP_READ);
      if (a_op == OP_READ) dout_q <= rd_word;
    end
  end

  assign dq_o  = dout_q;
  assign dq_oe = drv_q && !oe_n;

  AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    cke_n |=> ($stable(dq_o) && $stable(drv_q))); // R2

  AST_WRITE_WINDOW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (en && a_op == OP_WRITE) |=> !dq_oe); // R6
endmodule

// File: tb/test_pipe_sram.sv
module test_pipe_sram;
  localparam int AW = 6;
  localparam int DW = 18;

  // 250 MHz: 4 ns period at 1 ns per unit
  logic clk = 1'b0;
  logic rst_n = 1'b0, cke_n = 1'b1;
  logic sel1_n = 1'b1, sel2 = 1'b0, sel3_n = 1'b1;
  logic we_n = 1'b1, adv_ld_n = 1'b0, burst_il = 1'b0, oe_n = 1'b0;
  logic [1:0]    bw_n = 2'b11;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dq_i = '0;
  logic [DW-1:0] dq_o;
  logic          dq_oe;

  int checks = 0, errors = 0, en_edges = 0;
  bit done = 1'b0;

  logic [DW-1:0] mdl [64];
  bit m_act = 0, m_wr = 0, m_il = 0;
  int m_base = 0, m_cnt = 0;

  // scoreboard queues (parallel)
  int            sb_due[$];
  bit            sb_oe[$];
  logic [DW-1:0] sb_data[$];
  string         sb_req[$];
  int            wq_due[$];
  logic [DW-1:0] wq_data[$];

  always #2 clk = ~clk;

  pipe_sram i_pipe_sram (
    .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .sel1_n(sel1_n), .sel2(sel2),
    .sel3_n(sel3_n), .we_n(we_n), .bw_n(bw_n), .addr(addr), .adv_ld_n(adv_ld_n),
    .burst_il(burst_il), .oe_n(oe_n), .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe)
  );

  always @(posedge clk) if (rst_n && !cke_n) en_edges <= en_edges + 1;

  task automatic check(bit ok, string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // monitor: pops the item due in the window after each edge
  always @(posedge clk) begin
    #1;
    while (sb_due.size() > 0 && sb_due[0] < en_edges) begin
      check(1'b0, sb_req[0], "missed item", '0, '0);
      void'(sb_due.pop_front()); void'(sb_oe.pop_front());
      void'(sb_data.pop_front()); void'(sb_req.pop_front());
    end
    if (sb_due.size() > 0 && sb_due[0] == en_edges) begin
      check(dq_oe === sb_oe[0], sb_req[0], "drive enable", {17'b0, dq_oe}, {17'b0, sb_oe[0]});
      if (sb_oe[0]) check(dq_o === sb_data[0], sb_req[0], "read data", dq_o, sb_data[0]);
      void'(sb_due.pop_front()); void'(sb_oe.pop_front());
      void'(sb_data.pop_front()); void'(sb_req.pop_front());
    end
  end

  function automatic int eff(int base, int cnt, bit il);
    int lo = il ? ((base & 3) ^ (cnt & 3)) : ((base + cnt) & 3);
    return (base & ~3) | lo;
  endfunction

  task automatic push_exp(bit oe, logic [DW-1:0] d, string req);
    sb_due.push_back(en_edges + 2); sb_oe.push_back(oe);
    sb_data.push_back(d); sb_req.push_back(req);
  endtask

  task automatic begin_step();
    @(negedge clk);
    cke_n = 1'b0;
    while (wq_due.size() > 0 && wq_due[0] < en_edges) begin
      void'(wq_due.pop_front()); void'(wq_data.pop_front());
    end
    if (wq_due.size() > 0 && wq_due[0] == en_edges) dq_i = wq_data[0];
    else dq_i = 18'h2B5A3 ^ 18'(en_edges * 97);
  endtask

  task automatic apply(logic [1:0] bwn, logic [DW-1:0] d, string req);
    int ea = eff(m_base, m_cnt, m_il);
    if (m_wr) begin
      if (!bwn[0]) mdl[ea][8:0]  = d[8:0];
      if (!bwn[1]) mdl[ea][17:9] = d[17:9];
      wq_due.push_back(en_edges + 2); wq_data.push_back(d);
      push_exp(1'b0, '0, req);
    end else begin
      push_exp(1'b1, mdl[ea], req);
    end
  endtask

  // sel = {sel1_n, sel2, sel3_n}; 3'b010 selects the memory
  task automatic op_load(bit wr, int a, logic [1:0] bwn, logic [DW-1:0] d, bit il,
                         logic [2:0] sel, string req);
    begin_step();
    adv_ld_n = 1'b0; we_n = !wr; addr = AW'(a); bw_n = bwn; burst_il = il;
    {sel1_n, sel2, sel3_n} = sel;
    if (sel == 3'b010) begin
      m_act = 1; m_wr = wr; m_base = a; m_cnt = 0; m_il = il;
      apply(bwn, d, req);
    end else begin
      m_act = 0;
      push_exp(1'b0, '0, req);
    end
  endtask

  task automatic wr(int a, logic [DW-1:0] d, string req);
    op_load(1'b1, a, 2'b00, d, 1'b0, 3'b010, req);
  endtask

  task automatic rd(int a, string req);
    op_load(1'b0, a, 2'b00, '0, 1'b0, 3'b010, req);
  endtask

  // advance: we_n, selects, addr and burst_il are scrambled to show they are ignored
  task automatic op_adv(logic [1:0] bwn, logic [DW-1:0] d, string req);
    begin_step();
    adv_ld_n = 1'b1; we_n = !we_n; addr = ~addr; bw_n = bwn; burst_il = !m_il;
    {sel1_n, sel2, sel3_n} = 3'b101;
    if (m_act) begin
      m_cnt++;
      apply(bwn, d, req);
    end else begin
      push_exp(1'b0, '0, req);
    end
  endtask

  task automatic op_stall(string req);
    logic [DW-1:0] o;
    logic e;
    @(negedge clk);
    cke_n = 1'b1; adv_ld_n = 1'b0; we_n = 1'b0; {sel1_n, sel2, sel3_n} = 3'b010;
    addr = 6'h3F; bw_n = 2'b00; dq_i = 18'h3FFFF;
    o = dq_o; e = dq_oe;
    @(posedge clk); #1;
    check(dq_o === o, req, "held data", dq_o, o);
    check(dq_oe === e, req, "held enable", {17'b0, dq_oe}, {17'b0, e});
  endtask

  task automatic probe_oe(string req);
    oe_n = 1'b1;
    #1;
    check(dq_oe === 1'b0, req, "async disable", {17'b0, dq_oe}, 18'h0);
    oe_n = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      check(1'b0, "R3", "watchdog expired", '0, 18'h1);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(dq_oe === 1'b0, "R12", "reset enable", {17'b0, dq_oe}, 18'h0);
    check(dq_o === '0, "R12", "reset data", dq_o, '0);

    // plain writes then reads
    wr(3, 18'h11111, "R4"); wr(10, 18'h2A5A5, "R6"); wr(20, 18'h0F0F0, "R4");
    wr(33, 18'h3C3C3, "R6"); wr(40, 18'h12345, "R4"); wr(50, 18'h05555, "R4");
    rd(3, "R1"); rd(10, "R1");
    rd(20, "R1"); probe_oe("R11");
    rd(33, "R1");

    // alternating mix, forwarding from bus and pending slot
    wr(40, 18'h1ABCD, "R3"); rd(40, "R10"); wr(41, 18'h3FEDC, "R3"); rd(40, "R10");
    rd(41, "R10"); op_load(1'b1, 40, 2'b10, 18'h00077, 1'b0, 3'b010, "R4");
    rd(40, "R10"); op_load(1'b1, 40, 2'b01, 18'h3FE00, 1'b0, 3'b010, "R4");
    rd(40, "R10"); rd(40, "R3"); wr(41, 18'h00001, "R3"); wr(41, 18'h00002, "R3");
    rd(41, "R10");

    // byte-half write then read
    op_load(1'b1, 3, 2'b01, 18'h2AA00, 1'b0, 3'b010, "R4");
    rd(3, "R4");

    // each chip select alone blocks the write
    op_load(1'b1, 3, 2'b00, 18'h3FFFF, 1'b0, 3'b110, "R5");
    op_load(1'b1, 3, 2'b00, 18'h3FFFF, 1'b0, 3'b000, "R5");
    op_load(1'b1, 3, 2'b00, 18'h3FFFF, 1'b0, 3'b011, "R5");
    op_adv(2'b00, 18'h3FFFF, "R9");
    rd(3, "R5");

    // linear burst write from 6 (6,7,4,5), partial half on one beat
    op_load(1'b1, 6, 2'b00, 18'h00106, 1'b0, 3'b010, "R7");
    op_adv(2'b00, 18'h00107, "R9"); op_adv(2'b00, 18'h00104, "R7");
    op_adv(2'b10, 18'h20005, "R4");
    op_adv(2'b00, 18'h00206, "R7");
    // linear burst read from 5 with wrap
    op_load(1'b0, 5, 2'b00, '0, 1'b0, 3'b010, "R7");
    op_adv(2'b00, '0, "R7"); op_adv(2'b00, '0, "R7"); op_adv(2'b00, '0, "R7");
    op_adv(2'b00, '0, "R7"); op_adv(2'b00, '0, "R9");
    // interleaved read from 5 (5,4,7,6)
    op_load(1'b0, 5, 2'b00, '0, 1'b1, 3'b010, "R8");
    op_adv(2'b00, '0, "R8"); op_adv(2'b00, '0, "R8"); op_adv(2'b00, '0, "R8");
    // interleaved write from 13 (13,12,15,14), single reads back
    op_load(1'b1, 13, 2'b00, 18'h0D0D0, 1'b1, 3'b010, "R8");
    op_adv(2'b00, 18'h0C0C0, "R8"); op_adv(2'b00, 18'h0F0F0, "R8");
    op_adv(2'b00, 18'h0E0E0, "R8");
    rd(12, "R8"); rd(13, "R8"); rd(14, "R8"); rd(15, "R8");

    // stalls inside bursts and write/read mixes
    op_load(1'b0, 5, 2'b00, '0, 1'b0, 3'b010, "R2");
    op_adv(2'b00, '0, "R2"); op_stall("R2"); op_adv(2'b00, '0, "R2");
    op_stall("R2"); op_stall("R2"); op_adv(2'b00, '0, "R2");
    wr(50, 18'h13579, "R2"); op_stall("R2"); rd(50, "R2"); op_stall("R2");
    wr(51, 18'h2468A, "R2"); op_stall("R2"); op_stall("R2"); rd(51, "R10");
    rd(50, "R2");

    // drain
    op_load(1'b0, 0, 2'b11, '0, 1'b0, 3'b110, "R5");
    op_load(1'b0, 0, 2'b11, '0, 1'b0, 3'b110, "R5");
    op_load(1'b0, 0, 2'b11, '0, 1'b0, 3'b110, "R5");
    repeat (3) @(posedge clk);
    #1;
    check(sb_due.size() == 0, "R3", "results outstanding", 18'(sb_due.size()), 18'h0);
    done = 1'b1;
    finish_run();
  end
endmodule